// File: doc/BRIEF.md
# Pixel Hit-Time Recorder

This block is the digital tail of a single detector pixel. A global time count, shared by every pixel, advances through each bunch train. Each rising edge of the pixel's comparator output stores the time count of that moment into a small per-pixel store. That store keeps entries in arrival order and is wiped at the opening of every train. The analog front end is powered only while a train is in progress. Between trains, an external scanner tests the pixel through a single hit flag, reads its entry count and overflow bit, and fetches the stored entries one by one by index.

The comparator is modelled as an asynchronous digital input. A chain of flip-flops resynchronises it before edge detection. Each stored entry has two check bits, which let the readout path detect upsets in the stored time values.

A three-state controller owns the train window. In IDLE the front end is off and readout is open. When the train input is seen high, IDLE goes to CLEAR. CLEAR spends one cycle wiping the store and then goes to LIVE, or back to IDLE if the train has already ended. In LIVE the front end is on and hits are recorded. When the train input is seen low, LIVE returns to IDLE.

Top module: `pixel_tstamp_store`

## Requirements
- R1: After reset, fe_en_o, hit_o, ovf_o, count_o and rd_data_o are all zero.
- R2: The first clock edge that samples train_i high causes one clear cycle, which empties the store and drops the overflow bit. fe_en_o rises at the next edge if train_i is still high. fe_en_o falls at the first edge that samples train_i low.
- R3: A comparator rise that is first sampled at edge i is stored at edge i+2, with the tcount_i value present at that edge. This happens only if fe_en_o is high just before edge i+2.
- R4: Entry format: bits 11:0 hold the time value. Bit 12 is the XOR of time bits 5:0. Bit 13 is the XOR of time bits 11:6.
- R5: Entries are read back in arrival order. Index 0 is the oldest entry.
- R6: A comparator pulse held high over many cycles records exactly one entry.
- R7: A hit that arrives while four entries are held changes no entry. Instead it sets ovf_o, which stays set until the next clear cycle.
- R8: count_o gives the number of valid entries, from 0 to 4. hit_o is high exactly when count_o is non-zero.
- R9: rd_data_o returns the entry at rd_idx_i only in IDLE, and only when rd_idx_i is less than count_o. At all other times it is zero, including the whole time fe_en_o is high.
- R10: Comparator rises whose capture edge falls outside the LIVE window leave the store, the count and the overflow bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| train_i | input | 1 | High while a bunch train is in progress |
| tcount_i | input | 12 | Global bunch-crossing time count |
| comp_i | input | 1 | Comparator output (asynchronous) |
| rd_idx_i | input | 2 | Entry index for readout |
| fe_en_o | output | 1 | Analog front-end enable |
| hit_o | output | 1 | Pixel holds at least one entry |
| count_o | output | 3 | Number of valid entries |
| ovf_o | output | 1 | Sticky overflow flag |
| rd_data_o | output | 14 | Selected entry: check bits and time value |

## Verification
The bench builds the block with its default parameters: a 12-bit time, four entries, two synchroniser stages and two check groups. With only four entries, random trains of moderate hit density overflow often, so the no-overwrite and sticky-flag paths get regular use. A time base started near 4095 walks the stored values through the 12-bit wrap. Directed trains place pulses on the first and last capturable edges of the window and just past it, so the two-cycle capture latency is checked against the enable window at both ends.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_LIVE  = 2'd2
    } win_state_e;
endpackage

// File: rtl/pxl_window_fsm.sv
module pxl_window_fsm
    import pxl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic train_i,
    output logic clr_o,
    output logic live_o,
    output logic idle_o
);
    win_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: IDLE->CLEAR on train, CLEAR->LIVE or back to IDLE, LIVE->IDLE when train ends
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (train_i)  state_d = ST_CLEAR;
            ST_CLEAR: state_d = train_i ? ST_LIVE : ST_IDLE;
            ST_LIVE:  if (!train_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // decoded outputs
    always_comb begin
        clr_o  = 1'b0;
        live_o = 1'b0;
        idle_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle_o = 1'b1;
            ST_CLEAR: clr_o  = 1'b1;
            ST_LIVE:  live_o = 1'b1;
            default:  idle_o = 1'b1;
        endcase
    end

    // R2: front end only on after a train-high sample
    a_r2_live_needs_train: assert property (@(posedge clk) disable iff (!rst_n)
        live_o |-> $past(train_i));
    // R2: LIVE is entered only through the clear cycle
    a_r2_live_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (live_o && !$past(live_o)) |-> $past(clr_o));
endmodule

// File: rtl/pxl_edge_sync.sv
module pxl_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], d_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R6: a rise lasts a single cycle
    a_r6_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pxl_chk_enc.sv
module pxl_chk_enc #(
    parameter int TS_W  = 12,
    parameter int CHK_W = 2
) (
    input  logic [TS_W-1:0]       t_i,
    output logic [TS_W+CHK_W-1:0] e_o
);
    localparam int GRP = TS_W / CHK_W;
    logic [CHK_W-1:0] chk;

    for (genvar g = 0; g < CHK_W; g++) begin : g_grp
        assign chk[g] = ^t_i[g*GRP +: GRP];
    end

    assign e_o = {chk, t_i};
endmodule

// File: rtl/pxl_hit_store.sv
module pxl_hit_store #(
    parameter int DEPTH = 4,
    parameter int ENT_W = 14,
    parameter int CNT_W = 3,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             wr_i,
    input  logic [ENT_W-1:0] ent_i,
    input  logic             rd_en_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [ENT_W-1:0] rd_data_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    logic [CNT_W-1:0]            cnt_q;
    logic                        ovf_q;
    logic [DEPTH-1:0][ENT_W-1:0] mem_w;
    logic                        full;

    assign full = (cnt_q == CNT_W'(DEPTH));

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        logic [ENT_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              slot_q <= '0;
            else if (clr_i)                          slot_q <= '0;
            else if (wr_i && cnt_q == CNT_W'(k))     slot_q <= ent_i;
        end
        assign mem_w[k] = slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr_i) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (wr_i) begin
            if (full) ovf_q <= 1'b1;
            else      cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_en_i && (CNT_W'(rd_idx_i) < cnt_q))
            rd_data_o = mem_w[rd_idx_i];
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    // R8: count never exceeds depth
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    // R7: a full store keeps its contents until cleared
    a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr_i) |=> $stable(mem_w));
    // R7: overflow is sticky
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_i) |=> ovf_q);
    // R2: clear cycle empties the store
    a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0 && !ovf_q));
    // R5: an accepted hit appends one entry
    a_r5_append: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !full && !clr_i) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/pixel_tstamp_store.sv
module pixel_tstamp_store
    import pxl_pkg::*;
#(
    parameter int TS_W   = 12,
    parameter int CHK_W  = 2,
    parameter int DEPTH  = 4,
    parameter int STAGES = 2,
    localparam int ENT_W = TS_W + CHK_W,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             train_i,
    input  logic [TS_W-1:0]  tcount_i,
    input  logic             comp_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             fe_en_o,
    output logic             hit_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic [ENT_W-1:0] rd_data_o
);
    logic clr, live, idle, rise;
    logic [ENT_W-1:0] ent;

    pxl_window_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .train_i(train_i),
        .clr_o  (clr),
        .live_o (live),
        .idle_o (idle)
    );

    pxl_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (comp_i),
        .rise_o(rise)
    );

    pxl_chk_enc #(.TS_W(TS_W), .CHK_W(CHK_W)) u_enc (
        .t_i(tcount_i),
        .e_o(ent)
    );

    pxl_hit_store #(.DEPTH(DEPTH), .ENT_W(ENT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .wr_i     (live & rise),
        .ent_i    (ent),
        .rd_en_i  (idle),
        .rd_idx_i (rd_idx_i),
        .rd_data_o(rd_data_o),
        .cnt_o    (count_o),
        .ovf_o    (ovf_o)
    );

    assign fe_en_o = live;
    assign hit_o   = (count_o != '0);

    // R9: no readout data while the front end is on
    a_r9_rd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fe_en_o |-> (rd_data_o == '0));
    // R10: outside LIVE and CLEAR the count cannot move
    a_r10_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !train_i) |=> $stable(count_o));
endmodule

// File: tb/pixel_tstamp_store_tb.sv
module pixel_tstamp_store_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        train_i = 1'b0;
    logic [11:0] tcount_i = '0;
    logic        comp_i = 1'b0;
    logic [1:0]  rd_idx_i = '0;
    logic        fe_en_o, hit_o, ovf_o;
    logic [2:0]  count_o;
    logic [13:0] rd_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit pat [0:127];
    logic [13:0] exp_ent [4];
    int exp_cnt;
    bit exp_ovf;

    always #4 clk = ~clk;

    pixel_tstamp_store u_dut (
        .clk(clk), .rst_n(rst_n), .train_i(train_i), .tcount_i(tcount_i),
        .comp_i(comp_i), .rd_idx_i(rd_idx_i), .fe_en_o(fe_en_o), .hit_o(hit_o),
        .count_o(count_o), .ovf_o(ovf_o), .rd_data_o(rd_data_o)
    );

    function automatic logic [13:0] enc(input int t);
        logic [11:0] v;
        v = 12'(t);
        return {^v[11:6], ^v[5:0], v};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic clear_pat();
        for (int i = 0; i < 128; i++) pat[i] = 1'b0;
    endtask

    // mark a comparator-high slot (slot c stored at index c+3)
    task automatic set_slot(input int c);
        pat[c + 3] = 1'b1;
    endtask

    task automatic run_train(input int len, input int t0);
        exp_cnt = 0;
        exp_ovf = 1'b0;
        for (int i = 0; i <= len + 5; i++) begin
            if (pat[i + 3] && !pat[i + 2]) begin
                if (i + 2 >= 2 && i + 2 <= len) begin   // R3 / R10 window
                    if (exp_cnt < 4) begin
                        exp_ent[exp_cnt] = enc(t0 + i + 2);
                        exp_cnt++;
                    end else begin
                        exp_ovf = 1'b1;
                    end
                end
            end
        end
        for (int c = -3; c <= len + 5; c++) begin
            bit fe_now;
            @(negedge clk);
            fe_now = fe_en_o;
            chk(fe_now == (c >= 2 && c <= len), "R2 fe_en window", fe_now, (c >= 2 && c <= len));
            train_i  = (c >= 0 && c < len);
            comp_i   = pat[c + 3];
            tcount_i = 12'(t0 + c);
            rd_idx_i = 2'($urandom_range(0, 3));
            #1;
            if (fe_now) chk(rd_data_o == '0, "R9 readout during live", rd_data_o, 0);
        end
        @(negedge clk);
        train_i = 1'b0;
        comp_i  = 1'b0;
        chk(count_o == 3'(exp_cnt), "R8 count", count_o, exp_cnt);
        chk(hit_o == (exp_cnt != 0), "R8 hit flag", hit_o, (exp_cnt != 0));
        chk(ovf_o == exp_ovf, "R7 overflow", ovf_o, exp_ovf);
        for (int k = 0; k < 4; k++) begin
            logic [13:0] want;
            want = (k < exp_cnt) ? exp_ent[k] : 14'h0;
            rd_idx_i = 2'(k);
            #1;
            chk(rd_data_o == want, "R3 R4 R5 R9 entry", rd_data_o, want);
        end
    endtask

    initial begin
        #(8 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        clear_pat();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(fe_en_o == 1'b0, "R1 fe_en", fe_en_o, 0);
        chk(hit_o == 1'b0, "R1 hit", hit_o, 0);
        chk(count_o == '0, "R1 count", count_o, 0);
        chk(ovf_o == 1'b0, "R1 ovf", ovf_o, 0);
        chk(rd_data_o == '0, "R1 rd_data", rd_data_o, 0);

        // R6 long pulse gives one entry
        clear_pat();
        for (int c = 3; c <= 15; c++) set_slot(c);
        run_train(20, 100);

        // R7 five separate pulses: four kept, overflow set
        clear_pat();
        set_slot(2); set_slot(5); set_slot(8); set_slot(11); set_slot(14);
        run_train(30, 700);

        // R2 empty train clears previous contents and overflow
        clear_pat();
        run_train(6, 50);

        // R3 R10 first and last capturable edges, then a late pulse ignored
        clear_pat();
        set_slot(0); set_slot(8); set_slot(11);
        run_train(10, 2000);

        // R4 time values across the 12-bit wrap
        clear_pat();
        set_slot(1); set_slot(4); set_slot(7);
        run_train(16, 4090);

        // constrained random trains
        for (int n = 0; n < 40; n++) begin
            int len, dens;
            len  = $urandom_range(4, 40);
            dens = $urandom_range(1, 6);
            clear_pat();
            for (int c = 0; c <= len + 2; c++)
                pat[c + 3] = ($urandom_range(0, 9) < dens);
            run_train(len, $urandom_range(0, 4095));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule